// File: doc/BRIEF.md
# Byte-Wide SRAM with Shadow Nonvolatile Copy: Transfer Controller

This block is the control core of a byte-wide static memory that keeps a shadow nonvolatile copy of its contents. Software sees an ordinary asynchronous-style SRAM bus with active-low chip enable, output enable and write enable, an address and separate data-in and data-out lines with an output-enable flag. All of these are sampled on the rising clock edge. The block holds the working SRAM array and the shadow array. Both are single-port memories with a registered read, so block RAM can be used for them.

There are three transfers. An automatic store saves the SRAM into the shadow when the supply-warning input rises, but only if a write has happened since the last transfer. A software store runs after six read accesses hit a programmed address list in order. A recall copies the shadow back into the SRAM once a low-power event has been seen and both power inputs are low again. Every store first erases the shadow and then copies the SRAM into it. The bus is locked out while a transfer runs, and the `busy` output is high for the whole transfer.

Top module: `nvsram_ctrl`

## Requirements
- R1: When `ce_n`=0, `oe_n`=0 and `we_n`=1 are sampled while no transfer runs and `pwr_warn` and `pwr_lost` are both 0, then after that edge `dq_oe`=1 and `dq_o` holds the byte stored at the sampled address. The output follows a new address every cycle with no change on the control inputs.
- R2: When `ce_n`=0 and `we_n`=0 are sampled under the same conditions, `dq_i` is written to the sampled address. After that edge `dq_oe`=0, whatever the value of `oe_n`.
- R3: A store first fills the shadow with `ERASE_VAL` and then copies every SRAM byte into it. `busy` stays high for exactly (DEPTH+ERASE_WAIT)+(DEPTH+1+PROG_WAIT) cycles.
- R4: A rising edge on `pwr_warn` while the write-since-transfer flag is set starts a store, and `busy` rises within two cycles.
- R5: A rising edge on `pwr_warn` while the flag is clear starts no transfer, and `busy` stays low.
- R6: `pwr_lost`=1 latches a recall request. The recall starts once `pwr_warn` and `pwr_lost` are both 0 and copies the whole shadow into the SRAM. `busy` stays high for exactly DEPTH+1+REST_WAIT cycles.
- R7: Six read accesses in a row to `SEQ_ADDR[0]` through `SEQ_ADDR[5]`, in that order, start a store even when the flag is clear. A read access is a cycle that decodes as a read and is not a continuation of a read at the same address in the previous cycle.
- R8: A write access, or a read access to an address other than the next one in the list, cancels a partly matched sequence. A cancelling read to `SEQ_ADDR[0]` counts as the first step of a new sequence.
- R9: After reset, `busy`=0 and `dq_oe`=0. While `busy`=1, `dq_oe` stays 0 and bus writes are ignored.
- R10: When a store or a recall completes, the write-since-transfer flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all bus inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_i | input | DATA_W | Write data from the bus |
| dq_o | output | DATA_W | Read data to the bus |
| dq_oe | output | 1 | High when `dq_o` should drive the bus |
| pwr_warn | input | 1 | Supply has dropped below the store threshold |
| pwr_lost | input | 1 | Supply has dropped below the reset threshold |
| busy | output | 1 | A store or recall is in progress |

## Verification
The bench uses a 32-byte configuration. It writes and reads back every address with four different arithmetic byte patterns, so a stale, shifted or partial copy shows up as a wrong byte at a known address. Power-warning edges are applied with the flag set and with it clear, after a write, after a store and after a recall, which separates a gated store from an unconditional one. Unlock sequences are run complete, cut by a write, cut by a stray read, and restarted by a repeated first address. Together these show whether the matcher counts accesses, resets on any break and re-arms on the first address.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;
  typedef enum logic [1:0] {
    XF_IDLE   = 2'd0,
    XF_ERASE  = 2'd1,
    XF_PROG   = 2'd2,
    XF_RECALL = 2'd3
  } xfer_st_e;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;
endpackage

// File: rtl/nvsram_spram.sv
module nvsram_spram #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/nvsram_bus_dec.sv
module nvsram_bus_dec
  import nvsram_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          bus_en,
  output logic          rd_fire,
  output logic          wr_fire,
  output logic          rd_evt,
  output logic          wr_evt
);
  acc_e          prev_kind;
  logic [AW-1:0] prev_addr;
  logic          same_addr;

  assign rd_fire   = bus_en && !ce_n && !oe_n && we_n;
  assign wr_fire   = bus_en && !ce_n && !we_n;
  assign same_addr = (prev_addr == addr);
  assign rd_evt    = rd_fire && !(prev_kind == ACC_RD && same_addr);
  assign wr_evt    = wr_fire && !(prev_kind == ACC_WR && same_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_kind <= ACC_NONE;
      prev_addr <= '0;
    end else begin
      prev_addr <= addr;
      if (wr_fire)      prev_kind <= ACC_WR;
      else if (rd_fire) prev_kind <= ACC_RD;
      else              prev_kind <= ACC_NONE;
    end
  end
endmodule

// File: rtl/nvsram_unlock.sv
module nvsram_unlock #(
  parameter int AW    = 13,
  parameter int SEQ_N = 6,
  parameter logic [SEQ_N-1:0][AW-1:0] SEQ_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_evt,
  input  logic          wr_evt,
  input  logic [AW-1:0] addr,
  output logic          sw_go
);
  localparam int IW = (SEQ_N > 1) ? $clog2(SEQ_N) : 1;
  localparam logic [IW-1:0] LAST = IW'(SEQ_N - 1);

  logic [SEQ_N-1:0] hit;
  logic [IW-1:0]    idx;

  for (genvar i = 0; i < SEQ_N; i++) begin : g_hit
    assign hit[i] = (addr == SEQ_ADDR[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      sw_go <= 1'b0;
    end else begin
      sw_go <= 1'b0;
      if (wr_evt) begin
        idx <= '0;
      end else if (rd_evt) begin
        if (hit[idx]) begin
          if (idx == LAST) begin
            sw_go <= 1'b1;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end else if (hit[0]) begin
          idx <= IW'(1);
        end else begin
          idx <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/nvsram_xfer.sv
module nvsram_xfer
  import nvsram_pkg::*;
#(
  parameter int AW         = 13,
  parameter int ERASE_WAIT = 4,
  parameter int PROG_WAIT  = 4,
  parameter int REST_WAIT  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_warn,
  input  logic          pwr_lost,
  input  logic          sw_go,
  input  logic          wr_fire,
  output logic          busy,
  output logic          go,
  output logic          dirty,
  output logic          nv_we,
  output logic          nv_erase,
  output logic [AW-1:0] nv_addr,
  output logic          sr_own,
  output logic          sr_we,
  output logic [AW-1:0] sr_xaddr
);
  localparam int DEPTH     = 1 << AW;
  localparam int ERASE_LEN = DEPTH + ERASE_WAIT;
  localparam int PROG_LEN  = DEPTH + 1 + PROG_WAIT;
  localparam int REST_LEN  = DEPTH + 1 + REST_WAIT;
  localparam int LONGEST   = DEPTH + 2 + ERASE_WAIT + PROG_WAIT + REST_WAIT;
  localparam int CNT_W     = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] ERASE_END = CNT_W'(ERASE_LEN - 1);
  localparam logic [CNT_W-1:0] PROG_END  = CNT_W'(PROG_LEN - 1);
  localparam logic [CNT_W-1:0] REST_END  = CNT_W'(REST_LEN - 1);
  localparam logic [CNT_W-1:0] DEPTH_C   = CNT_W'(DEPTH);

  xfer_st_e         st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_m1;
  logic             warn_q;
  logic             ast_pend;
  logic             rcl_pend;
  logic             store_go;
  logic             rcl_ok;
  logic             in_copy;

  assign store_go = ast_pend || sw_go;
  assign rcl_ok   = rcl_pend && !pwr_warn && !pwr_lost;
  assign go       = (st == XF_IDLE) && (store_go || rcl_ok);
  assign busy     = (st != XF_IDLE);
  assign cnt_m1   = cnt - 1'b1;
  assign in_copy  = (cnt != '0) && (cnt <= DEPTH_C);

  assign nv_erase = (st == XF_ERASE);
  assign nv_we    = ((st == XF_ERASE) && (cnt < DEPTH_C)) ||
                    ((st == XF_PROG) && in_copy);
  assign nv_addr  = (st == XF_PROG) ? cnt_m1[AW-1:0] : cnt[AW-1:0];
  assign sr_own   = (st == XF_PROG) || (st == XF_RECALL);
  assign sr_we    = (st == XF_RECALL) && in_copy;
  assign sr_xaddr = (st == XF_RECALL) ? cnt_m1[AW-1:0] : cnt[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= XF_IDLE;
      cnt      <= '0;
      warn_q   <= 1'b0;
      ast_pend <= 1'b0;
      rcl_pend <= 1'b0;
      dirty    <= 1'b0;
    end else begin
      warn_q <= pwr_warn;
      if (pwr_warn && !warn_q && dirty) ast_pend <= 1'b1;
      if (pwr_lost)                     rcl_pend <= 1'b1;
      if (wr_fire)                      dirty    <= 1'b1;

      unique case (st)
        XF_IDLE: begin
          cnt <= '0;
          if (store_go) begin
            st       <= XF_ERASE;
            ast_pend <= 1'b0;
          end else if (rcl_ok) begin
            st       <= XF_RECALL;
            rcl_pend <= 1'b0;
          end
        end
        XF_ERASE: begin
          if (cnt == ERASE_END) begin
            st  <= XF_PROG;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        XF_PROG: begin
          if (cnt == PROG_END) begin
            st    <= XF_IDLE;
            cnt   <= '0;
            dirty <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        XF_RECALL: begin
          if (cnt == REST_END) begin
            st    <= XF_IDLE;
            cnt   <= '0;
            dirty <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= XF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int SEQ_N      = 6,
  parameter logic [SEQ_N-1:0][ADDR_W-1:0] SEQ_ADDR = {
    ADDR_W'(13'h01E7), ADDR_W'(13'h0123), ADDR_W'(13'h00F0),
    ADDR_W'(13'h015A), ADDR_W'(13'h00C3), ADDR_W'(13'h01A5)},
  parameter int ERASE_WAIT = 4,
  parameter int PROG_WAIT  = 4,
  parameter int REST_WAIT  = 4,
  parameter logic [DATA_W-1:0] ERASE_VAL = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  input  logic              pwr_warn,
  input  logic              pwr_lost,
  output logic              busy
);
  logic              bus_en;
  logic              rd_fire, wr_fire, rd_evt, wr_evt;
  logic              sw_go, go, dirty;
  logic              nv_we, nv_erase, sr_own, x_sr_we;
  logic [ADDR_W-1:0] nv_addr, sr_xaddr;
  logic              sr_we;
  logic [ADDR_W-1:0] sr_addr;
  logic [DATA_W-1:0] sr_wdata, sr_q, nv_wdata, nv_q;

  assign bus_en = !busy && !go && !pwr_warn && !pwr_lost;

  nvsram_bus_dec #(.AW(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .bus_en(bus_en), .rd_fire(rd_fire), .wr_fire(wr_fire),
    .rd_evt(rd_evt), .wr_evt(wr_evt)
  );

  nvsram_unlock #(.AW(ADDR_W), .SEQ_N(SEQ_N), .SEQ_ADDR(SEQ_ADDR)) u_unl (
    .clk(clk), .rst(rst), .rd_evt(rd_evt), .wr_evt(wr_evt),
    .addr(addr), .sw_go(sw_go)
  );

  nvsram_xfer #(
    .AW(ADDR_W), .ERASE_WAIT(ERASE_WAIT), .PROG_WAIT(PROG_WAIT),
    .REST_WAIT(REST_WAIT)
  ) u_xf (
    .clk(clk), .rst(rst), .pwr_warn(pwr_warn), .pwr_lost(pwr_lost),
    .sw_go(sw_go), .wr_fire(wr_fire), .busy(busy), .go(go), .dirty(dirty),
    .nv_we(nv_we), .nv_erase(nv_erase), .nv_addr(nv_addr),
    .sr_own(sr_own), .sr_we(x_sr_we), .sr_xaddr(sr_xaddr)
  );

  assign sr_we    = sr_own ? x_sr_we : wr_fire;
  assign sr_addr  = sr_own ? sr_xaddr : addr;
  assign sr_wdata = sr_own ? nv_q : dq_i;
  assign nv_wdata = nv_erase ? ERASE_VAL : sr_q;

  nvsram_spram #(.AW(ADDR_W), .DW(DATA_W)) u_sram (
    .clk(clk), .we(sr_we), .addr(sr_addr), .wdata(sr_wdata), .rdata(sr_q)
  );

  nvsram_spram #(.AW(ADDR_W), .DW(DATA_W)) u_shadow (
    .clk(clk), .we(nv_we), .addr(nv_addr), .wdata(nv_wdata), .rdata(nv_q)
  );

  always_ff @(posedge clk) begin
    if (rst) dq_oe <= 1'b0;
    else     dq_oe <= rd_fire;
  end

  assign dq_o = sr_q;
endmodule

// File: rtl/nvsram_chk.sv
module nvsram_chk #(
  parameter int ADDR_W     = 13,
  parameter int ERASE_WAIT = 4,
  parameter int PROG_WAIT  = 4,
  parameter int REST_WAIT  = 4
) (
  input logic clk,
  input logic rst,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic pwr_warn,
  input logic pwr_lost,
  input logic busy,
  input logic dq_oe,
  input logic dirty
);
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int STORE_LEN = 2 * DEPTH + 1 + ERASE_WAIT + PROG_WAIT;
  localparam int REST_LEN  = DEPTH + 1 + REST_WAIT;

  logic [31:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R9
  lockout_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !dq_oe);

  // R2
  wr_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!ce_n && !we_n) |-> !dq_oe);

  // R1
  rd_drive_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!ce_n && !oe_n && we_n && !busy && !pwr_warn && !pwr_lost) && !busy)
      |-> dq_oe);

  // R3 R6
  xfer_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == STORE_LEN || run_len == REST_LEN));

  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !dirty);
endmodule

bind nvsram_ctrl nvsram_chk #(
  .ADDR_W(ADDR_W), .ERASE_WAIT(ERASE_WAIT), .PROG_WAIT(PROG_WAIT),
  .REST_WAIT(REST_WAIT)
) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .pwr_warn(pwr_warn), .pwr_lost(pwr_lost), .busy(busy), .dq_oe(dq_oe),
  .dirty(dirty)
);

// File: tb/sim_nvsram_ctrl.sv
module sim_nvsram_ctrl;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int EW = 3, PW = 2, RW = 4;
  localparam int STORE_LEN = (DEPTH + EW) + (DEPTH + 1 + PW);
  localparam int REST_LEN  = DEPTH + 1 + RW;
  localparam logic [5:0][AW-1:0] SEQ = {5'h06, 5'h11, 5'h03, 5'h1C, 5'h0A, 5'h15};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic dq_oe, busy;
  logic pwr_warn = 1'b0, pwr_lost = 1'b0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  nvsram_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .SEQ_N(6), .SEQ_ADDR(SEQ),
    .ERASE_WAIT(EW), .PROG_WAIT(PW), .REST_WAIT(RW), .ERASE_VAL(8'hFF)
  ) u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
    .pwr_warn(pwr_warn), .pwr_lost(pwr_lost), .busy(busy)
  );

  function automatic logic [DW-1:0] pat(int p, int a);
    case (p)
      0: return DW'(a * 37 + 5);
      1: return ~DW'(a * 37 + 5);
      2: return DW'(a * 11 + 8'h60);
      default: return DW'(a) ^ 8'hC3;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1; oe_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    ce_n = 0; oe_n = 0; we_n = 0; addr = AW'(a); dq_i = d;
    @(negedge clk);
  endtask

  task automatic rd(int a);
    ce_n = 0; oe_n = 0; we_n = 1; addr = AW'(a);
    @(negedge clk);
  endtask

  task automatic fill(int p);
    int bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      wr(a, pat(p, a));
      if (dq_oe) bad++;
    end
    idle();
    // R2: writes store data and never enable the output drivers
    chk(bad == 0, "R2 dq_oe during writes", bad, 0);
  endtask

  task automatic readall(int p, string tag);
    int bad = 0;
    int last_a = 0;
    logic [DW-1:0] last_v = '0;
    for (int a = 0; a < DEPTH; a++) begin
      rd(a);
      if (!dq_oe || dq_o !== pat(p, a)) begin
        if (bad == 0) begin last_a = a; last_v = dq_o; end
        bad++;
      end
    end
    idle();
    chk(bad == 0, tag, int'(last_v), int'(pat(p, last_a)));
  endtask

  task automatic wait_busy(int exp, string tag);
    int n = 0;
    int g = 0;
    while (!busy && g < 8) begin g++; @(negedge clk); end
    while (busy && n < 10000) begin n++; @(negedge clk); end
    chk(n == exp, tag, n, exp);
  endtask

  task automatic no_busy(int cyc, string tag);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (busy) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic seq_rd(int from, int to);
    for (int i = from; i <= to; i++) begin
      rd(int'(SEQ[i]));
      idle();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk(busy == 0, "R9 reset busy", busy, 0);
    chk(dq_oe == 0, "R9 reset dq_oe", dq_oe, 0);

    // R1 R2: write and read back, forward and reverse order
    fill(0);
    readall(0, "R1 readback ascending");
    begin
      int bad = 0;
      for (int a = DEPTH - 1; a >= 0; a--) begin
        rd(a);
        if (dq_o !== pat(0, a)) bad++;
      end
      idle();
      chk(bad == 0, "R1 address follow descending", bad, 0);
    end

    // R4 R3: supply warning with the flag set; bus writes attempted while busy (R9)
    pwr_warn = 1;
    @(negedge clk);
    pwr_warn = 0;
    ce_n = 0; oe_n = 1; we_n = 0; addr = 0; dq_i = 8'h5A;
    wait_busy(STORE_LEN, "R4 R3 auto store busy length");
    idle();
    readall(0, "R9 write during busy ignored");

    // R10 R5: flag cleared by the completed store, next warning is skipped
    pwr_warn = 1;
    no_busy(6, "R5 R10 warning after store skipped");
    pwr_warn = 0;
    idle();

    // R6: overwrite, then recall brings the stored copy back
    fill(1);
    pwr_lost = 1;
    @(negedge clk);
    @(negedge clk);
    pwr_lost = 0;
    wait_busy(REST_LEN, "R6 recall busy length");
    readall(0, "R6 recalled contents");
    pwr_warn = 1;
    no_busy(6, "R10 warning after recall skipped");
    pwr_warn = 0;
    idle();

    // R7: software store with the flag clear
    seq_rd(0, 5);
    wait_busy(STORE_LEN, "R7 software store while clean");
    idle();

    // R7 R3: software store copies the current contents
    fill(2);
    seq_rd(0, 5);
    wait_busy(STORE_LEN, "R7 software store length");
    idle();
    fill(3);
    pwr_lost = 1;
    @(negedge clk);
    pwr_lost = 0;
    wait_busy(REST_LEN, "R6 second recall length");
    readall(2, "R7 R3 stored contents recalled");

    // R8: a write cancels the sequence
    seq_rd(0, 2);
    wr(7, 8'h77);
    idle();
    seq_rd(3, 5);
    no_busy(6, "R8 write aborts sequence");

    // R8: a stray read cancels the sequence
    seq_rd(0, 1);
    rd(5'h1F);
    idle();
    seq_rd(2, 5);
    no_busy(6, "R8 stray read aborts sequence");

    // R8: a repeated first address restarts matching
    seq_rd(0, 1);
    seq_rd(0, 5);
    wait_busy(STORE_LEN, "R8 restart on first address");
    idle();

    // R7: a read held over several cycles counts once
    rd(int'(SEQ[0]));
    rd(int'(SEQ[0]));
    rd(int'(SEQ[0]));
    idle();
    seq_rd(1, 5);
    wait_busy(STORE_LEN, "R7 held read counts once");
    idle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule